// File: doc/BRIEF.md
# Registered Burst Initiator Sequencer

This block is the initiator side of a parallel bus on which every input is registered before any decision is made. A local agent hands it one transaction at a time: a bus command, a word-aligned start address, a byte count, a tag, a requester identity and three extra status bits. The block drives an address phase, then one attribute phase that announces the whole transfer, then waits for a target to claim the cycle. Once the target signals readiness, the block streams a burst whose length is fixed before its first data phase. It never pauses that burst. The transaction ends with a one-cycle completion pulse that carries a termination code and the number of bytes moved.

Every bus input passes through a sampling register, and the state machine acts on the registered copy. A bus event in cycle k can therefore change the block's outputs no earlier than cycle k+2. Because the burst length is known in advance, FRAME# is released exactly two clocks before the last data phase. For very short bursts, the block inserts lead cycles before data so that this two-clock spacing still holds. A target stop request that arrives together with ready is honoured only at a 128-byte address boundary. The block shortens the burst to end on that boundary before the burst starts.

States: IDLE (accepts a request), ADDR (address phase), ATTR (attribute phase), WDEV (waits for a claim, counting a window), WTGT (claimed, waits for ready or stop), LEAD (FRAME# already high, data not yet started), DATA (one data phase per clock). Transitions: IDLE→ADDR on a request; ADDR→ATTR and ATTR→WDEV unconditionally; WDEV→WTGT on a sampled claim; WDEV→IDLE when the window expires (master abort); WTGT→DATA or WTGT→LEAD on sampled ready; WTGT→IDLE on sampled stop without ready (retry); LEAD→DATA when the lead count runs out; DATA→IDLE after the last phase.

Top module: `rbi_initiator`

## Requirements
- R1: While reset is held, frame_n and irdy_n are high, ad_oe is low, and busy and done are low.
- R2: In the cycle after a request is accepted in IDLE, the block drives the address phase: frame_n low, ad_oe high, ad_out equal to the address, cbe_n equal to the 4-bit command. Bit 0 of the command set to 1 selects a write, and 0 selects a read.
- R3: The next cycle is the single attribute phase. It has frame_n low and ad_oe high, with ad_out[31:16] = requester ID, ad_out[15:12] = tag[3:0], ad_out[11:0] = byte count, cbe_n[0] = tag[4] and cbe_n[3:1] = status bits. These bits are driven as-is, not inverted.
- R4: The target may claim by driving devsel_n low on any of the DEV_WIN (default 4) clocks that follow the attribute phase. If it does not, done rises DEV_WIN+2 clocks after the attribute phase with code 3 (master abort) and 0 bytes, frame_n is high in that cycle, and irdy_n never falls.
- R5: Let k be the first cycle in which trdy_n is low, at least one clock after the claim. The first data phase falls in cycle k+2+max(0,3-N), where N is the number of data phases.
- R6: During the burst, irdy_n stays low for exactly N consecutive cycles, with no wait cycle. cbe_n is 0 in each data phase.
- R7: frame_n rises in the cycle two clocks before the final data phase and stays high until the transaction ends.
- R8: For a write, each data phase drives ad_out equal to wr_data with ad_oe and wr_take high. The local side advances wr_data after each cycle in which wr_take is high.
- R9: For a read, rd_valid is high in the cycle after each data phase, N times in total. rd_data then equals the ad_in value of that data phase.
- R10: If stop_n is low without trdy_n after the claim, done rises two clocks later with code 2 (retry) and 0 bytes, and no data phase occurs.
- R11: If stop_n and trdy_n go low together, the burst is cut to end at the first 128-byte address boundary when that boundary lies before the requested end, with code 1 (disconnect). Otherwise the full burst runs with code 0.
- R12: done is high for one cycle, the cycle after the final data phase. It reports code 0 (normal) and a byte count of 4 times N.
- R13: A byte count of 0 requests 4096 bytes (1024 data phases).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_cmd | input | 4 | Bus command, bit 0 selects write |
| req_addr | input | 32 | Word-aligned start address |
| req_bytes | input | 12 | Byte count, multiple of 4, 0 means 4096 |
| req_tag | input | 5 | Transaction tag |
| req_rid | input | 16 | Requester identity |
| req_xst | input | 3 | Extra status bits for the attribute phase |
| wr_data | input | 32 | Write data for the current data phase |
| busy | output | 1 | A transaction is in progress |
| wr_take | output | 1 | Current write word is being transferred |
| rd_valid | output | 1 | rd_data holds a read word |
| rd_data | output | 32 | Read word |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 2 | 0 normal, 1 disconnect, 2 retry, 3 master abort |
| done_bytes | output | 13 | Bytes transferred |
| ad_out | output | 32 | Address/data bus value |
| ad_oe | output | 1 | Address/data bus drive enable |
| cbe_n | output | 4 | Command / byte enable lines |
| frame_n | output | 1 | Transaction framing, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| ad_in | input | 32 | Address/data bus as seen from the target |
| devsel_n | input | 1 | Target claim, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop request, active low |

## Verification
The in-RTL properties watch several rules on every cycle. IRDY# never gaps inside a burst. FRAME# rises exactly two clocks before the last data phase. The first data phase trails the target's ready by at least two clocks. The completion pulse lasts one cycle. A retry reports no bytes, and a disconnect always ends on a 128-byte boundary. The bench's scenarios are needed to show the exact cycle of each phase, the attribute bit packing, and the claim window edge, including a claim one clock too late that must still abort. They also cover the arithmetic of where a disconnect cuts the burst, the lead cycles for one- and two-phase bursts, and the 4096-byte encoding.

// File: rtl/rbi_pkg.sv
package rbi_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ATTR,
        S_WDEV,
        S_WTGT,
        S_LEAD,
        S_DATA
    } state_t;

    typedef enum logic [1:0] {
        TC_NORMAL = 2'd0,
        TC_DISC   = 2'd1,
        TC_RETRY  = 2'd2,
        TC_ABORT  = 2'd3
    } term_t;

endpackage

// File: rtl/rbi_sampler.sv
// Registers every target-driven bus input; the sequencer sees only these copies.
module rbi_sampler #(
    parameter int AD_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] ad_in,
    input  logic            devsel_n,
    input  logic            trdy_n,
    input  logic            stop_n,
    output logic [AD_W-1:0] ad_q,
    output logic            devsel_q,
    output logic            trdy_q,
    output logic            stop_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ad_q     <= '0;
            devsel_q <= 1'b0;
            trdy_q   <= 1'b0;
            stop_q   <= 1'b0;
        end else begin
            ad_q     <= ad_in;
            devsel_q <= ~devsel_n;
            trdy_q   <= ~trdy_n;
            stop_q   <= ~stop_n;
        end
    end

endmodule

// File: rtl/rbi_planner.sv
// Burst length arithmetic: requested phases and phases left before the next boundary.
module rbi_planner #(
    parameter int BC_W  = 12,
    parameter int WB    = 2,
    parameter int BND_W = 7,
    parameter int PH_W  = 11
) (
    input  logic [BND_W-1:0] addr_lo,
    input  logic [BC_W-1:0]  bytes,
    output logic [PH_W-1:0]  n_full,
    output logic [PH_W-1:0]  n_bnd,
    output logic             cut
);

    logic [BND_W:0] room;

    always_comb begin
        room = {1'b1, {BND_W{1'b0}}} - {1'b0, addr_lo};
        n_bnd = PH_W'(room >> WB);
        if (bytes == '0) begin
            n_full = {1'b1, {(PH_W-1){1'b0}}};
        end else begin
            n_full = {1'b0, bytes[BC_W-1:WB]};
        end
        cut = (n_bnd < n_full);
    end

endmodule

// File: rtl/rbi_attr.sv
// Packs the attribute phase onto the address/data and command lines.
module rbi_attr #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4,
    parameter int BC_W  = 12,
    parameter int TAG_W = 5,
    parameter int RID_W = 16,
    parameter int XST_W = 3
) (
    input  logic [RID_W-1:0] rid,
    input  logic [TAG_W-1:0] tag,
    input  logic [BC_W-1:0]  bytes,
    input  logic [XST_W-1:0] xst,
    output logic [AD_W-1:0]  attr_ad,
    output logic [CBE_W-1:0] attr_cbe
);

    assign attr_ad  = {rid, tag[TAG_W-2:0], bytes};
    assign attr_cbe = {xst, tag[TAG_W-1]};

endmodule

// File: rtl/rbi_initiator.sv
module rbi_initiator
    import rbi_pkg::*;
#(
    parameter int AD_W      = 32,
    parameter int CBE_W     = 4,
    parameter int BC_W      = 12,
    parameter int TAG_W     = 5,
    parameter int RID_W     = 16,
    parameter int XST_W     = 3,
    parameter int DEV_WIN   = 4,
    parameter int BND_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CBE_W-1:0]  req_cmd,
    input  logic [AD_W-1:0]   req_addr,
    input  logic [BC_W-1:0]   req_bytes,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [RID_W-1:0]  req_rid,
    input  logic [XST_W-1:0]  req_xst,
    input  logic [AD_W-1:0]   wr_data,
    output logic              busy,
    output logic              wr_take,
    output logic              rd_valid,
    output logic [AD_W-1:0]   rd_data,
    output logic              done,
    output logic [1:0]        done_code,
    output logic [BC_W:0]     done_bytes,
    output logic [AD_W-1:0]   ad_out,
    output logic              ad_oe,
    output logic [CBE_W-1:0]  cbe_n,
    output logic              frame_n,
    output logic              irdy_n,
    input  logic [AD_W-1:0]   ad_in,
    input  logic              devsel_n,
    input  logic              trdy_n,
    input  logic              stop_n
);

    localparam int WB    = $clog2(AD_W / 8);
    localparam int BND_W = $clog2(BND_BYTES);
    localparam int PH_W  = BC_W - WB + 1;
    localparam int CNT_W = $clog2(DEV_WIN + 1);

    state_t st, st_nx;

    logic [AD_W-1:0]  a_q;
    logic [CBE_W-1:0] cmd_q;
    logic [BC_W-1:0]  bytes_q;
    logic [TAG_W-1:0] tag_q;
    logic [RID_W-1:0] rid_q;
    logic [XST_W-1:0] xst_q;
    logic             is_wr;
    logic [CNT_W-1:0] win_cnt;
    logic [1:0]       lead_cnt;
    logic [PH_W-1:0]  rem;
    logic [PH_W-1:0]  n_q;
    logic             disc_q;
    logic             done_q;
    term_t            code_q;
    logic [BC_W:0]    nbytes_q;
    logic             rdv_q;

    logic             devsel_q, trdy_q, stop_q;
    logic [AD_W-1:0]  ad_q;
    logic [PH_W-1:0]  n_full, n_bnd, n_eff;
    logic             cut;
    logic [1:0]       lead_need;
    logic [AD_W-1:0]  attr_ad;
    logic [CBE_W-1:0] attr_cbe;

    rbi_sampler #(.AD_W(AD_W)) u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ad_in    (ad_in),
        .devsel_n (devsel_n),
        .trdy_n   (trdy_n),
        .stop_n   (stop_n),
        .ad_q     (ad_q),
        .devsel_q (devsel_q),
        .trdy_q   (trdy_q),
        .stop_q   (stop_q)
    );

    rbi_planner #(.BC_W(BC_W), .WB(WB), .BND_W(BND_W), .PH_W(PH_W)) u_plan (
        .addr_lo (a_q[BND_W-1:0]),
        .bytes   (bytes_q),
        .n_full  (n_full),
        .n_bnd   (n_bnd),
        .cut     (cut)
    );

    rbi_attr #(
        .AD_W(AD_W), .CBE_W(CBE_W), .BC_W(BC_W),
        .TAG_W(TAG_W), .RID_W(RID_W), .XST_W(XST_W)
    ) u_attr (
        .rid      (rid_q),
        .tag      (tag_q),
        .bytes    (bytes_q),
        .xst      (xst_q),
        .attr_ad  (attr_ad),
        .attr_cbe (attr_cbe)
    );

    // Burst length is settled at the ready decision; short bursts need lead cycles
    // so FRAME# can still rise two clocks ahead of the last phase.
    always_comb begin
        n_eff = (stop_q && cut) ? n_bnd : n_full;
        if (n_eff == PH_W'(1)) begin
            lead_need = 2'd2;
        end else if (n_eff == PH_W'(2)) begin
            lead_need = 2'd1;
        end else begin
            lead_need = 2'd0;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (req_valid) st_nx = S_ADDR;
            S_ADDR: st_nx = S_ATTR;
            S_ATTR: st_nx = S_WDEV;
            S_WDEV: begin
                if (devsel_q) begin
                    st_nx = S_WTGT;
                end else if (win_cnt == CNT_W'(DEV_WIN)) begin
                    st_nx = S_IDLE;
                end
            end
            S_WTGT: begin
                if (trdy_q) begin
                    st_nx = (lead_need != 2'd0) ? S_LEAD : S_DATA;
                end else if (stop_q) begin
                    st_nx = S_IDLE;
                end
            end
            S_LEAD: if (lead_cnt == 2'd1) st_nx = S_DATA;
            S_DATA: if (rem == PH_W'(1)) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            a_q      <= '0;
            cmd_q    <= '0;
            bytes_q  <= '0;
            tag_q    <= '0;
            rid_q    <= '0;
            xst_q    <= '0;
            is_wr    <= 1'b0;
            win_cnt  <= '0;
            lead_cnt <= '0;
            rem      <= '0;
            n_q      <= '0;
            disc_q   <= 1'b0;
            done_q   <= 1'b0;
            code_q   <= TC_NORMAL;
            nbytes_q <= '0;
            rdv_q    <= 1'b0;
        end else begin
            st     <= st_nx;
            done_q <= 1'b0;
            rdv_q  <= (st == S_DATA) && !is_wr;
            unique case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        a_q     <= req_addr;
                        cmd_q   <= req_cmd;
                        bytes_q <= req_bytes;
                        tag_q   <= req_tag;
                        rid_q   <= req_rid;
                        xst_q   <= req_xst;
                        is_wr   <= req_cmd[0];
                    end
                end
                S_ADDR: ;
                S_ATTR: win_cnt <= '0;
                S_WDEV: begin
                    win_cnt <= win_cnt + CNT_W'(1);
                    if (!devsel_q && win_cnt == CNT_W'(DEV_WIN)) begin
                        done_q   <= 1'b1;
                        code_q   <= TC_ABORT;
                        nbytes_q <= '0;
                    end
                end
                S_WTGT: begin
                    if (trdy_q) begin
                        rem      <= n_eff;
                        n_q      <= n_eff;
                        lead_cnt <= lead_need;
                        disc_q   <= stop_q && cut;
                    end else if (stop_q) begin
                        done_q   <= 1'b1;
                        code_q   <= TC_RETRY;
                        nbytes_q <= '0;
                    end
                end
                S_LEAD: lead_cnt <= lead_cnt - 2'd1;
                S_DATA: begin
                    rem <= rem - PH_W'(1);
                    if (rem == PH_W'(1)) begin
                        done_q   <= 1'b1;
                        code_q   <= disc_q ? TC_DISC : TC_NORMAL;
                        nbytes_q <= {n_q, {WB{1'b0}}};
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        frame_n = 1'b1;
        irdy_n  = 1'b1;
        ad_oe   = 1'b0;
        ad_out  = '0;
        cbe_n   = '1;
        wr_take = 1'b0;
        unique case (st)
            S_IDLE: ;
            S_ADDR: begin
                frame_n = 1'b0;
                ad_oe   = 1'b1;
                ad_out  = a_q;
                cbe_n   = cmd_q;
            end
            S_ATTR: begin
                frame_n = 1'b0;
                ad_oe   = 1'b1;
                ad_out  = attr_ad;
                cbe_n   = attr_cbe;
            end
            S_WDEV, S_WTGT: frame_n = 1'b0;
            S_LEAD: ;
            S_DATA: begin
                irdy_n  = 1'b0;
                frame_n = (rem <= PH_W'(3)) ? 1'b1 : 1'b0;
                cbe_n   = '0;
                ad_oe   = is_wr;
                ad_out  = is_wr ? wr_data : '0;
                wr_take = is_wr;
            end
            default: ;
        endcase
    end

    assign busy       = (st != S_IDLE);
    assign done       = done_q;
    assign done_code  = code_q;
    assign done_bytes = nbytes_q;
    assign rd_valid   = rdv_q;
    assign rd_data    = ad_q;

    logic             last_ph;
    logic [BND_W-1:0] fin_lo;
    assign last_ph = (st == S_DATA) && (rem == PH_W'(1));
    assign fin_lo  = a_q[BND_W-1:0] + done_bytes[BND_W-1:0];

    AST_ATTR_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |=> !frame_n); // R3
    AST_DATA_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irdy_n) |-> !$past(trdy_n, 2)); // R5
    AST_NO_WAIT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && !last_ph) |=> !irdy_n); // R6
    AST_FRAME_TWO_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        last_ph |-> (frame_n && $past(frame_n, 2) && !$past(frame_n, 3))); // R7
    AST_RETRY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_code == TC_RETRY) |-> (done_bytes == '0)); // R10
    AST_DISC_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_code == TC_DISC) |-> (fin_lo == '0)); // R11
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

endmodule

// File: tb/rbi_initiator_test.sv
`timescale 1ns/1ps
module rbi_initiator_test;

    localparam int DEV_WIN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_cmd = '0;
    logic [31:0] req_addr = '0;
    logic [11:0] req_bytes = '0;
    logic [4:0]  req_tag = '0;
    logic [15:0] req_rid = '0;
    logic [2:0]  req_xst = '0;
    logic [31:0] wr_data = '0;
    logic        busy, wr_take, rd_valid, done, ad_oe, frame_n, irdy_n;
    logic [31:0] rd_data, ad_out;
    logic [1:0]  done_code;
    logic [12:0] done_bytes;
    logic [3:0]  cbe_n;
    logic [31:0] ad_in = '0;
    logic        devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;

    int checks = 0;
    int fails = 0;
    int last_bytes = 0;

    always #2.5 clk = ~clk;

    rbi_initiator #(.DEV_WIN(DEV_WIN)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_tag(req_tag),
        .req_rid(req_rid), .req_xst(req_xst), .wr_data(wr_data), .busy(busy),
        .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
        .done_code(done_code), .done_bytes(done_bytes), .ad_out(ad_out),
        .ad_oe(ad_oe), .cbe_n(cbe_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad_in(ad_in), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rpat(input int t);
        return 32'h9E370000 ^ (32'(t) * 32'h00010003);
    endfunction

    function automatic logic [31:0] wpat(input int j);
        return 32'hC0DE0000 + 32'(j) * 32'h00000101;
    endfunction

    // mode: 0 ready only, 1 ready with stop, 2 stop only; dev_d 0 = never claim
    task automatic run(input bit wr, input logic [31:0] addr, input logic [11:0] bytes,
                       input int dev_d, input int gap, input int mode);
        int nfull, pb, ne, kd, k, s, last, done_t, fr_rise, code, nb, beats;
        bit claimed;
        string ctag;
        logic [4:0]  tg;
        logic [15:0] rid;
        logic [2:0]  xs;
        logic [3:0]  cmd;
        tg  = 5'(addr[8:4] ^ bytes[6:2] ^ 5'(gap));
        rid = 16'h4A00 ^ addr[15:0];
        xs  = 3'(dev_d + mode);
        cmd = wr ? 4'h7 : 4'h6;
        nfull = (bytes == 0) ? 1024 : int'(bytes) / 4;
        claimed = (dev_d >= 1) && (dev_d <= DEV_WIN);
        kd = (dev_d >= 1) ? 2 + dev_d : 1000000;
        k = claimed ? kd + 1 + gap : 1000000;
        s = -10; last = -20; nb = 0;
        if (!claimed) begin
            done_t = 4 + DEV_WIN; code = 3; ctag = "R4";
            fr_rise = done_t;
        end else if (mode == 2) begin
            done_t = k + 2; code = 2; ctag = "R10";
            fr_rise = done_t;
        end else begin
            pb = 32 - int'(addr[6:2]);
            if (mode == 1 && pb < nfull) begin
                ne = pb; code = 1; ctag = "R11";
            end else begin
                ne = nfull; code = 0; ctag = "R12";
            end
            s = k + 2 + ((ne < 3) ? 3 - ne : 0);
            last = s + ne - 1;
            done_t = last + 1;
            fr_rise = last - 2;
            nb = ne * 4;
        end
        beats = 0;
        wr_data = wpat(0);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_bytes = bytes;
        req_tag = tg; req_rid = rid; req_xst = xs;
        for (int t = 1; t <= done_t; t++) begin
            @(negedge clk);
            req_valid = 1'b0;
            chk(frame_n == ((t < fr_rise) ? 1'b0 : 1'b1), "R7", "frame_n", frame_n, t);
            chk(irdy_n == ((t >= s && t <= last) ? 1'b0 : 1'b1), "R6", "irdy_n", irdy_n, t);
            if (t == s) chk(irdy_n == 1'b0, "R5", "first data cycle", t, s);
            if (t == 1) begin
                chk(ad_oe && ad_out == addr, "R2", "address", ad_out, addr);
                chk(cbe_n == cmd, "R2", "command", cbe_n, cmd);
            end
            if (t == 2) begin
                chk(ad_oe && ad_out == {rid, tg[3:0], bytes}, "R3", "attr ad", ad_out,
                    {rid, tg[3:0], bytes});
                chk(cbe_n == {xs, tg[4]}, "R3", "attr cbe", cbe_n, {xs, tg[4]});
            end
            if (t >= s && t <= last) begin
                chk(cbe_n == 4'h0, "R6", "byte enables", cbe_n, 0);
                if (wr) begin
                    chk(ad_oe && wr_take && ad_out == wpat(t - s), "R8", "write word",
                        ad_out, wpat(t - s));
                end else begin
                    chk(!ad_oe && !wr_take, "R9", "read bus idle", ad_oe, 0);
                end
            end
            chk(rd_valid == (!wr && t >= s + 1 && t <= last + 1), "R9", "rd_valid", rd_valid, t);
            if (!wr && t >= s + 1 && t <= last + 1)
                chk(rd_data == rpat(t - 1), "R9", "read word", rd_data, rpat(t - 1));
            chk(done == (t == done_t), "R12", "done timing", done, t);
            chk(busy == (t < done_t), "R12", "busy", busy, t);
            if (t == done_t) begin
                chk(done_code == 2'(code), ctag, "code", done_code, code);
                chk(int'(done_bytes) == nb, ctag, "bytes", done_bytes, nb);
                last_bytes = int'(done_bytes);
            end
            if (wr_take) beats++;
            wr_data = wpat(beats);
            ad_in = rpat(t);
            if (t == done_t) begin
                devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
            end else begin
                devsel_n = !(dev_d >= 1 && t >= kd);
                trdy_n   = !(mode != 2 && t >= k);
                stop_n   = !(mode >= 1 && t >= k);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(frame_n && irdy_n && !ad_oe && !busy && !done, "R1", "reset state",
            {frame_n, irdy_n, ad_oe, busy, done}, 5'b11000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // Normal bursts: direction x length x claim latency x ready gap
        for (int w = 0; w < 2; w++)
            for (int n = 1; n <= 6; n++)
                for (int d = 1; d <= DEV_WIN; d++)
                    for (int g = 0; g <= 2; g++)
                        run(w[0], 32'h1000_0000 + 32'(n * 64), 12'(n * 4), d, g, 0);
        // Disconnect around a 128-byte boundary (R11)
        for (int w = 0; w < 2; w++)
            for (int off = 1; off <= 8; off++)
                for (int n = 1; n <= 10; n++)
                    run(w[0], 32'h2000_0100 - 32'(off * 4), 12'(n * 4), 1, 0, 1);
        // Retry (R10)
        for (int d = 1; d <= DEV_WIN; d++)
            for (int g = 0; g <= 1; g++)
                run(d[0], 32'h3000_0040, 12'd16, d, g, 2);
        // Master abort: no claim, and a claim one clock past the window (R4)
        run(1'b0, 32'h4000_0000, 12'd8, 0, 0, 0);
        run(1'b1, 32'h4000_0010, 12'd8, DEV_WIN + 1, 0, 0);
        // Zero byte count means 4096 bytes (R13)
        run(1'b0, 32'h5000_0000, 12'd0, 2, 1, 0);
        chk(last_bytes == 4096, "R13", "full-size burst bytes", last_bytes, 4096);
        run(1'b1, 32'h5000_0000, 12'd0, 1, 0, 1);
        chk(last_bytes == 128, "R13", "full-size burst cut at boundary", last_bytes, 128);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule